// File: doc/BRIEF.md
# XGMII Receive Frame Start Checker

This block sits on the receive side of a 10 Gb/s link, after the physical coding layer has produced a deskewed 32-bit XGMII column (four byte lanes plus one control bit per lane) each clock. It decides which columns belong to a properly started frame and marks those bytes as valid toward the MAC. The byte and control bits are passed on unchanged with a register stage.

A frame is accepted only when the Start control character occupies lane 0 and the next column carries the start-of-frame delimiter in lane 3. Frames that break either rule are discarded until the next Terminate. Inside an accepted frame, Error characters are gathered into one errored flag. A frame that ends on anything other than a Terminate is closed as errored, so an Error that replaces a Terminate can never look like a clean end. Local and remote fault ordered sets are flagged as two separate pulses.

Lane 0 is `rxd[7:0]`, and lane 3 is `rxd[31:24]`. All outputs are registered and follow the input column by exactly one clock.

Top module: `xgmii_rx_start_check`

## Requirements
- R1: A synchronous active-high `rst` clears all output flags and `out_valid`. After reset, the block waits for a new Start and gives no valid lanes until it sees one.
- R2: `out_data` and `out_ctrl` equal `rxd` and `rxc` from the previous clock, whatever the framing state.
- R3: A Start character (control bit 1, byte 0xFB) is honoured only in lane 0. A Start in lanes 1 to 3 never leads to a nonzero `out_valid`.
- R4: After a lane-0 Start, the next column must have all four control bits 0 and byte 0xD5 in lane 3. That column is output with `out_valid` = 4'b1111 and a one-clock `out_sof`. Otherwise nothing is marked valid until a Terminate has been seen.
- R5: Columns inside an accepted frame that contain no ending character are output with `out_valid` = 4'b1111.
- R6: A Terminate (control bit 1, byte 0xFD) in lane k of a frame column marks only lanes below k valid and pulses `out_eof`. The next column has `out_valid` = 0.
- R7: An Error character (control bit 1, byte 0xFE) in any lane of an accepted frame makes `out_err` 1 on that frame's `out_eof` column.
- R8: Inside a frame, a control character that is neither Error nor Terminate ends the frame at that lane with `out_eof` = 1 and `out_err` = 1. An example is an Idle (0x07) that follows an Error which replaced the Terminate.
- R9: A column with control bits 4'b0001, lane 0 = 0x9C, and lanes 1 and 2 = 0x00 is an ordered set. If lane 3 = 0x01, `out_local_fault` pulses. If lane 3 = 0x02, `out_remote_fault` pulses.
- R10: `out_err` is only ever 1 together with `out_eof`. A frame that ends on a Terminate with no Error inside has `out_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 32 | Receive column, lane 0 in bits 7:0 |
| rxc | input | 4 | Per-lane control flags |
| out_data | output | 32 | Registered copy of `rxd` |
| out_ctrl | output | 4 | Registered copy of `rxc` |
| out_valid | output | 4 | Per-lane data-valid toward the MAC |
| out_sof | output | 1 | Pulse on the delimiter column of an accepted frame |
| out_eof | output | 1 | Pulse on the column where an accepted frame ends |
| out_err | output | 1 | Errored-frame flag, given with `out_eof` |
| out_local_fault | output | 1 | Local fault ordered set seen |
| out_remote_fault | output | 1 | Remote fault ordered set seen |

## Verification
The properties assume that `rxd` and `rxc` are stable, already-deskewed columns, one per clock, with lane 0 in the low byte. They also assume that reset is held for at least one edge before any traffic. The stimulus builds every column from whole Start, delimiter, data, Error, Idle, Terminate and ordered-set patterns that match these assumptions. Columns are applied on the falling edge, so each one is stable at the rising edge. Partial-frame cases, such as a misplaced Start, a missing delimiter and a reset in mid-frame, are still made only of legal columns.

// File: rtl/xrx_pkg.sv
package xrx_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    localparam logic [LANE_W-1:0] C_START  = 8'hFB;
    localparam logic [LANE_W-1:0] C_TERM   = 8'hFD;
    localparam logic [LANE_W-1:0] C_ERR    = 8'hFE;
    localparam logic [LANE_W-1:0] C_SEQ    = 8'h9C;
    localparam logic [LANE_W-1:0] D_SFD    = 8'hD5;
    localparam logic [LANE_W-1:0] F_LOCAL  = 8'h01;
    localparam logic [LANE_W-1:0] F_REMOTE = 8'h02;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_SFD,
        ST_FRAME,
        ST_DROP
    } fr_state_t;

    typedef struct packed {
        logic start;
        logic term;
        logic err;
        logic endc;   // control that closes a frame (anything but Error)
    } lane_cls_t;

    typedef struct packed {
        lane_mask_t valid;
        logic       sof;
        logic       eof;
        logic       err;
    } fr_out_t;

    // isolate the lowest set lane
    function automatic lane_mask_t lowest_lane(input lane_mask_t m);
        return m & (~m + 1'b1);
    endfunction

    // lanes strictly below the lowest set lane (all lanes when none set)
    function automatic lane_mask_t lanes_below(input lane_mask_t m);
        return lowest_lane(m) - 1'b1;
    endfunction
endpackage

// File: rtl/xrx_lane_decode.sv
module xrx_lane_decode
    import xrx_pkg::*;
(
    input  logic [LANE_W-1:0] byte_in,
    input  logic              ctl_in,
    output lane_cls_t         cls
);
    always_comb begin
        cls.start = ctl_in && (byte_in == C_START);
        cls.term  = ctl_in && (byte_in == C_TERM);
        cls.err   = ctl_in && (byte_in == C_ERR);
        cls.endc  = ctl_in && (byte_in != C_ERR);
    end
endmodule

// File: rtl/xrx_fault_detect.sv
module xrx_fault_detect
    import xrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rxd,
    input  logic [LANES-1:0]  rxc,
    output logic              local_fault,
    output logic              remote_fault
);
    localparam int TOP_LO = DATA_W - LANE_W;

    logic seq_col;
    logic [LANE_W-1:0] code_byte;

    always_comb begin
        seq_col = (rxc == lane_mask_t'(1)) && (rxd[LANE_W-1:0] == C_SEQ)
                  && (rxd[TOP_LO-1:LANE_W] == '0);
        code_byte = rxd[DATA_W-1:TOP_LO];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            local_fault  <= 1'b0;
            remote_fault <= 1'b0;
        end else begin
            local_fault  <= seq_col && (code_byte == F_LOCAL);
            remote_fault <= seq_col && (code_byte == F_REMOTE);
        end
    end
endmodule

// File: rtl/xrx_frame_fsm.sv
module xrx_frame_fsm
    import xrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lane_mask_t start_m,
    input  lane_mask_t term_m,
    input  lane_mask_t err_m,
    input  lane_mask_t endc_m,
    input  logic       sfd_ok,
    output fr_out_t    out_q
);
    fr_state_t  st, st_n;
    logic       err_acc, err_acc_n;
    fr_out_t    out_n;
    lane_mask_t keep;
    lane_mask_t first_end;

    always_comb begin
        st_n      = st;
        err_acc_n = err_acc;
        out_n     = '0;
        keep      = lanes_below(endc_m);
        first_end = lowest_lane(endc_m);
        unique case (st)
            ST_IDLE: begin
                if (start_m[0]) st_n = ST_WAIT_SFD;
            end
            ST_WAIT_SFD: begin
                if (sfd_ok) begin
                    st_n      = ST_FRAME;
                    out_n.valid = '1;
                    out_n.sof = 1'b1;
                    err_acc_n = 1'b0;
                end else begin
                    st_n = (|term_m) ? ST_IDLE : ST_DROP;
                end
            end
            ST_FRAME: begin
                if (|endc_m) begin
                    st_n        = ST_IDLE;
                    out_n.valid = keep;
                    out_n.eof   = 1'b1;
                    out_n.err   = err_acc || (|(err_m & keep))
                                  || !(|(term_m & first_end));
                    err_acc_n   = 1'b0;
                end else begin
                    out_n.valid = '1;
                    err_acc_n   = err_acc || (|err_m);
                end
            end
            ST_DROP: begin
                if (|term_m) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            err_acc <= 1'b0;
            out_q   <= '0;
        end else begin
            st      <= st_n;
            err_acc <= err_acc_n;
            out_q   <= out_n;
        end
    end
endmodule

// File: rtl/xgmii_rx_start_check.sv
module xgmii_rx_start_check
    import xrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] rxd,
    input  logic [LANES-1:0]  rxc,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_ctrl,
    output logic [LANES-1:0]  out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_local_fault,
    output logic              out_remote_fault
);
    lane_cls_t  cls [LANES];
    lane_mask_t start_m, term_m, err_m, endc_m;
    logic       sfd_ok;
    fr_out_t    fr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xrx_lane_decode u_dec (
            .byte_in (rxd[g*LANE_W +: LANE_W]),
            .ctl_in  (rxc[g]),
            .cls     (cls[g])
        );
        assign start_m[g] = cls[g].start;
        assign term_m[g]  = cls[g].term;
        assign err_m[g]   = cls[g].err;
        assign endc_m[g]  = cls[g].endc;
    end

    assign sfd_ok = (rxc == '0) && (rxd[DATA_W-1 -: LANE_W] == D_SFD);

    xrx_frame_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start_m (start_m),
        .term_m  (term_m),
        .err_m   (err_m),
        .endc_m  (endc_m),
        .sfd_ok  (sfd_ok),
        .out_q   (fr)
    );

    xrx_fault_detect u_fault (
        .clk          (clk),
        .rst          (rst),
        .rxd          (rxd),
        .rxc          (rxc),
        .local_fault  (out_local_fault),
        .remote_fault (out_remote_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_ctrl <= '0;
        end else begin
            out_data <= rxd;
            out_ctrl <= rxc;
        end
    end

    assign out_valid = fr.valid;
    assign out_sof   = fr.sof;
    assign out_eof   = fr.eof;
    assign out_err   = fr.err;
endmodule

// File: rtl/xrx_start_check_sva.sv
module xrx_start_check_sva
    import xrx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] rxd,
    input logic [LANES-1:0]  rxc,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  out_ctrl,
    input logic [LANES-1:0]  out_valid,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_err
);
    a_r2_passthrough: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_data == $past(rxd)) && (out_ctrl == $past(rxc)));

    a_r3_start_in_lane0: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> $past(rxc[0] && (rxd[LANE_W-1:0] == C_START), 2));

    a_r4_sfd_lane3: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> $past((rxc == '0) && (rxd[DATA_W-1 -: LANE_W] == D_SFD)));

    a_r4_first_valid_is_sof: assert property (@(posedge clk) disable iff (rst)
        ((|out_valid) && !$past(|out_valid)) |-> out_sof);

    a_r6_idle_after_eof: assert property (@(posedge clk) disable iff (rst)
        out_eof |=> (out_valid == '0));

    a_r6_valid_prefix: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid + 1'b1));

    a_r10_err_with_eof: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_eof);
endmodule

bind xgmii_rx_start_check xrx_start_check_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .rxd       (rxd),
    .rxc       (rxc),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_err   (out_err)
);

// File: tb/xgmii_rx_start_check_test.sv
module xgmii_rx_start_check_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rxd = 32'h07070707;
    logic [3:0]  rxc = 4'hF;
    logic [31:0] out_data;
    logic [3:0]  out_ctrl, out_valid;
    logic        out_sof, out_eof, out_err, out_lf, out_rf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    xgmii_rx_start_check uut (
        .clk(clk), .rst(rst), .rxd(rxd), .rxc(rxc),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid),
        .out_sof(out_sof), .out_eof(out_eof), .out_err(out_err),
        .out_local_fault(out_lf), .out_remote_fault(out_rf)
    );

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  c;
        logic [3:0]  v;
        logic        sof, eof, err, lf, rf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd1},  // R1 idle
        '{32'h555555FB, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 start
        '{32'hD5555555, 4'h0, 4'hF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 sfd
        '{32'h11223344, 4'h0, 4'hF, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
        '{32'h07FDBBAA, 4'hC, 4'h3, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'd6},  // R6 T lane2
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 after
        '{32'h5555FB07, 4'h3, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3 start lane1
        '{32'hD5555555, 4'h0, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{32'h99887766, 4'h0, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{32'h070707FD, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
        '{32'h555555FB, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4
        '{32'h55555555, 4'h0, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 no sfd
        '{32'h44556677, 4'h0, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 dropped
        '{32'hFD332211, 4'h8, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},  // R4 drop ends
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd4},
        '{32'h555555FB, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},
        '{32'hD5555555, 4'h0, 4'hF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd7},
        '{32'h3333FE33, 4'h2, 4'hF, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 E lane1
        '{32'h070707FD, 4'hF, 4'h0, 1'b0,1'b1,1'b1,1'b0,1'b0, 4'd7},  // R7
        '{32'h555555FB, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},
        '{32'hD5555555, 4'h0, 4'hF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd8},
        '{32'hFECCBBAA, 4'h8, 4'hF, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},  // R8 E as T
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b1,1'b1,1'b0,1'b0, 4'd8},  // R8
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd8},
        '{32'h0100009C, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'd9},  // R9 local
        '{32'h0200009C, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'd9},  // R9 remote
        '{32'h555555FB, 4'h1, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10},
        '{32'hD5555555, 4'h0, 4'hF, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'd10},
        '{32'hFDCCBBAA, 4'h8, 4'h7, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'd10}, // R10 good end
        '{32'h07070707, 4'hF, 4'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'd10}
    };

    task automatic apply(input logic [31:0] d, input logic [3:0] c);
        @(negedge clk);
        rxd = d;
        rxc = c;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [3:0] v,
                              input logic sof, input logic eof, input logic err,
                              input logic lf, input logic rf);
        checks++;
        if ({out_valid, out_sof, out_eof, out_err, out_lf, out_rf} !==
            {v, sof, eof, err, lf, rf}) begin
            fails++;
            $display("FAIL %s: got v=%h sof=%b eof=%b err=%b lf=%b rf=%b, want v=%h sof=%b eof=%b err=%b lf=%b rf=%b",
                     tag, out_valid, out_sof, out_eof, out_err, out_lf, out_rf,
                     v, sof, eof, err, lf, rf);
        end
    endtask

    task automatic expect_pass(input logic [31:0] d, input logic [3:0] c);
        checks++;
        if (out_data !== d || out_ctrl !== c) begin
            fails++;
            $display("FAIL R2: got %h/%h want %h/%h", out_data, out_ctrl, d, c);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 in reset", 4'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].d, VEC[i].c);
            expect_out($sformatf("R%0d vector %0d", VEC[i].req, i),
                       VEC[i].v, VEC[i].sof, VEC[i].eof, VEC[i].err,
                       VEC[i].lf, VEC[i].rf);
            expect_pass(VEC[i].d, VEC[i].c);
        end

        // R4: delimiter column carrying a control lane is rejected
        apply(32'h555555FB, 4'h1);
        apply(32'hD5555507, 4'h1);
        expect_out("R4 ctl in sfd column", 4'h0, 0, 0, 0, 0, 0);
        apply(32'h12345678, 4'h0);
        expect_out("R4 dropped data", 4'h0, 0, 0, 0, 0, 0);
        apply(32'h0707FD00, 4'hE);
        apply(32'h07070707, 4'hF);

        // R1: reset in mid-frame, following data stays invalid
        apply(32'h555555FB, 4'h1);
        apply(32'hD5555555, 4'h0);
        expect_out("R1 frame before reset", 4'hF, 1, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        expect_out("R1 reset mid-frame", 4'h0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        apply(32'hAABBCCDD, 4'h0);
        expect_out("R1 no start after reset", 4'h0, 0, 0, 0, 0, 0);
        apply(32'h070707FD, 4'hF);
        expect_out("R1 terminate after reset", 4'h0, 0, 0, 0, 0, 0);

        // R6: terminate in lane 0 gives empty final column
        apply(32'h555555FB, 4'h1);
        apply(32'hD5555555, 4'h0);
        apply(32'h070707FD, 4'hF);
        expect_out("R6 T lane0", 4'h0, 0, 1, 0, 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule